// File: doc/BRIEF.md
# Coin-Accumulating Gum Dispenser Controller

This controller counts coin credit for a gum dispenser that costs fifteen cents. Two sensor strobes report one coin per clock: a nickel worth five cents or a dime worth ten. The credit is kept as one of four levels: nothing, five, ten, or fifteen-and-above. Once the price is met, the block asserts a release signal.

The block returns no change. Any overpayment, such as two dimes, lands in the top level. The credit stays at that level, whatever coins follow, until the block is reset.

The release decision is available in two forms, both decoded from the same credit register:
- a registered form that depends on the credit level alone;
- an early form that also looks at the coin arriving in the current cycle. It announces the completing coin one cycle ahead of the registered form.

The reset input is asynchronous and active-low. Its release is synchronized to the clock before the credit register leaves its zero level.

Top module: `coin_vend_ctrl`

## Requirements
- R1: While reset is held and after it is released, credit is zero: both release outputs are low with no coin present.
- R2: A nickel advances credit by one level: zero to five, five to ten, and ten to the top level.
- R3: A dime advances credit by two levels and saturates: zero to ten, while five or ten go to the top level with no change returned.
- R4: A cycle with neither coin strobe high leaves the credit level unchanged.
- R5: Once at the top level, credit stays there for any coin input until reset.
- R6: `rel_state` is high exactly when the registered credit is at the top level, and it changes only at a clock edge.
- R7: `rel_early` is high when credit is at the top level, or a dime arrives at five or ten cents, or a nickel arrives at ten cents. It is low otherwise, for legal inputs where the two strobes are never high together.
- R8: On the coin that completes the price, `rel_early` rises in the same cycle as the coin, and `rel_state` rises one cycle later.
- R9: Driving `rst_n` low clears the credit without waiting for a clock edge. After `rst_n` rises, coins at the first two rising edges are ignored, and a coin at the third edge counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| coin_nickel | input | 1 | Five-cent coin strobe, one cycle per coin |
| coin_dime | input | 1 | Ten-cent coin strobe, one cycle per coin |
| rel_state | output | 1 | Release decoded from credit level only |
| rel_early | output | 1 | Release decoded from credit level and current coin |

## Verification
The embedded properties watch several cycle-to-cycle rules on every cycle:
- the top level holds once reached;
- an idle cycle keeps the credit;
- the early release implies the registered release one cycle later;
- the registered release never stands without the early one.

Only the directed scenarios can show the rest:
- the exact step sizes of each coin from each level, covered by a sweep of every level against every legal input;
- the asynchronous clear without a clock;
- the two ignored edges after the reset is lifted.

The bench reads the credit level through the ports alone. It holds each coin strobe briefly and watches the combinational early release.

// File: rtl/coin_vend_pkg.sv
package coin_vend_pkg;
  typedef enum logic [1:0] {
    CR_0  = 2'b00,
    CR_5  = 2'b01,
    CR_10 = 2'b10,
    CR_15 = 2'b11
  } credit_e;
endpackage

// File: rtl/coin_rst_sync.sv
module coin_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/coin_credit_next.sv
module coin_credit_next
  import coin_vend_pkg::*;
(
  input  credit_e cur,
  input  logic    nickel,
  input  logic    dime,
  output credit_e nxt
);
  always_comb begin
    nxt = cur;
    if (dime) begin
      unique case (cur)
        CR_0:    nxt = CR_10;
        default: nxt = CR_15;
      endcase
    end else if (nickel) begin
      unique case (cur)
        CR_0:    nxt = CR_5;
        CR_5:    nxt = CR_10;
        default: nxt = CR_15;
      endcase
    end
  end
endmodule

// File: rtl/coin_release_dec.sv
module coin_release_dec
  import coin_vend_pkg::*;
(
  input  credit_e cur,
  input  logic    nickel,
  input  logic    dime,
  output logic    rel_moore,
  output logic    rel_mealy
);
  always_comb begin
    rel_moore = (cur == CR_15);
    rel_mealy = (cur == CR_15)
              | (dime   & ((cur == CR_5) | (cur == CR_10)))
              | (nickel & (cur == CR_10));
  end
endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
  import coin_vend_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic coin_nickel,
  input  logic coin_dime,
  output logic rel_state,
  output logic rel_early
);
  logic    rst_sync_n;
  logic    credit_en;
  credit_e credit_q;
  credit_e credit_d;

  coin_rst_sync #(.STAGES(RST_STAGES)) u_rsync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  coin_credit_next u_next (
    .cur    (credit_q),
    .nickel (coin_nickel),
    .dime   (coin_dime),
    .nxt    (credit_d)
  );

  assign credit_en = coin_nickel | coin_dime;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)    credit_q <= CR_0;
    else if (credit_en) credit_q <= credit_d;
  end

  coin_release_dec u_dec (
    .cur       (credit_q),
    .nickel    (coin_nickel),
    .dime      (coin_dime),
    .rel_moore (rel_state),
    .rel_mealy (rel_early)
  );

  // R5
  top_holds_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (credit_q == CR_15) |=> (credit_q == CR_15));

  // R4
  idle_keeps_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!coin_nickel && !coin_dime) |=> $stable(credit_q));

  // R8
  early_leads_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rel_early && !rel_state) |=> rel_state);

  // R7
  state_implies_early_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rel_state |-> rel_early);

  // R3
  dime_saturates_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (coin_dime && !coin_nickel && credit_q != CR_0) |=> (credit_q == CR_15));
endmodule

// File: tb/sim_coin_vend_ctrl.sv
`timescale 1ns/100ps
module sim_coin_vend_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nk = 1'b0;
  logic dm = 1'b0;
  logic rel_state, rel_early;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  coin_vend_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .coin_nickel(nk), .coin_dime(dm),
    .rel_state(rel_state), .rel_early(rel_early)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Decode the credit level (in nickels) through the early-release output.
  task automatic probe(output int lvl);
    logic a, b, c;
    @(negedge clk);
    nk = 0; dm = 0; #0.5 a = rel_early;
    dm = 1;         #0.5 b = rel_early;
    dm = 0; nk = 1; #0.5 c = rel_early;
    nk = 0;
    lvl = a ? 3 : (c ? 2 : (b ? 1 : 0));
  endtask

  task automatic step(input logic n, input logic d);
    @(negedge clk); nk = n; dm = d;
    @(posedge clk); #1 nk = 0; dm = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); nk = 0; dm = 0; rst_n = 0;
    @(negedge clk); rst_n = 1;
    repeat (2) @(posedge clk);
  endtask

  task automatic go_to(input int lvl);
    do_reset();
    for (int i = 0; i < lvl; i++) step(1'b1, 1'b0);
  endtask

  task automatic t_reset();
    int lv;
    @(negedge clk); rst_n = 0; #0.5;
    check("R1 state during reset", rel_state, 0);
    check("R1 early during reset", rel_early, 0);
    @(negedge clk); rst_n = 1;
    repeat (2) @(posedge clk);
    probe(lv);
    check("R1 credit after reset", lv, 0);
  endtask

  task automatic t_nickels();
    int lv;
    do_reset();
    for (int i = 1; i <= 3; i++) begin
      step(1'b1, 1'b0);
      probe(lv);
      check("R2 nickel level", lv, i);
    end
    check("R6 state at top", rel_state, 1);
  endtask

  task automatic t_dimes();
    int lv;
    go_to(0); step(1'b0, 1'b1); probe(lv); check("R3 dime from 0", lv, 2);
    step(1'b0, 1'b1); probe(lv); check("R3 dime from 10 saturates", lv, 3);
    go_to(1); step(1'b0, 1'b1); probe(lv); check("R3 dime from 5", lv, 3);
  endtask

  task automatic t_idle();
    int lv;
    go_to(2);
    repeat (4) step(1'b0, 1'b0);
    probe(lv);
    check("R4 idle hold", lv, 2);
    check("R6 state low below top", rel_state, 0);
  endtask

  task automatic t_saturate();
    int lv;
    go_to(3);
    step(1'b1, 1'b0); step(1'b0, 1'b1); step(1'b0, 1'b0);
    probe(lv);
    check("R5 top holds", lv, 3);
    check("R5 state high", rel_state, 1);
  endtask

  task automatic t_sweep();
    int lv, nx, add;
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 3; c++) begin
        go_to(s);
        add = (c == 1) ? 1 : ((c == 2) ? 2 : 0);
        nx = (s + add > 3) ? 3 : s + add;
        @(negedge clk); nk = (c == 1); dm = (c == 2); #0.5;
        check($sformatf("R7 early s=%0d c=%0d", s, c), rel_early, (nx == 3) ? 1 : 0);
        check($sformatf("R6 state before edge s=%0d", s), rel_state, (s == 3) ? 1 : 0);
        @(posedge clk); #1 nk = 0; dm = 0;
        check($sformatf("R6 state after edge s=%0d c=%0d", s, c), rel_state, (nx == 3) ? 1 : 0);
        probe(lv);
        check($sformatf("R2/R3 next s=%0d c=%0d", s, c), lv, nx);
      end
    end
  endtask

  task automatic t_lead();
    go_to(2);
    @(negedge clk); nk = 1; #0.5;
    check("R8 early on completing coin", rel_early, 1);
    check("R8 state not yet", rel_state, 0);
    @(posedge clk); #1 nk = 0;
    check("R8 state one cycle later", rel_state, 1);
  endtask

  task automatic t_async();
    int lv;
    go_to(3);
    @(negedge clk); #0.5 rst_n = 0; #0.5;
    check("R9 async clear no edge", rel_state, 0);
    @(negedge clk); rst_n = 1; nk = 1;
    @(posedge clk); @(posedge clk); #1;
    check("R9 coins ignored two edges", rel_early, 0);
    @(posedge clk); #1 nk = 0;
    probe(lv);
    check("R9 third edge counts", lv, 1);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_nickels();
    t_dimes();
    t_idle();
    t_saturate();
    t_sweep();
    t_lead();
    t_async();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule